// File: doc/BRIEF.md
# Offline Supply Startup and Brownout Sequencer

This block supervises the power-up of an offline switching controller. Comparator outputs for the supply rail (above the inhibit, off, on, overvoltage and reset levels) and for the rectified line (above the start and stop levels) arrive as synchronised flags. A slow timebase tick drives every timer. The block decides which startup charging current is on, when the switching logic may run, and when a supply overvoltage has latched the controller into a quiet fault state.

Charging runs in two stages. The low current is used while the rail is below the inhibit level, and the high current above it. When the rail reaches the on level, both currents stop. Only then is the line judged. Switching is released once a fixed startup delay has elapsed and the line has been qualified above its start level. A line that stays below its stop level for a blanking time stops switching. A rail that stays below its off level for a timeout returns the block to charging. A rail that stays above the overvoltage level for long enough latches a fault that only a collapse of the rail below the reset level clears.

Top module: `supply_start_sequencer`

## Requirements
- R1: While charging and with `vcc_gt_inh` low, `istart_lo_en` is 1 and `istart_hi_en` is 0, in the same cycle as the input.
- R2: While charging, `vcc_gt_inh` high selects `istart_hi_en` (and clears `istart_lo_en`), and a drop of `vcc_gt_inh` back to 0 returns at once to the low current.
- R3: One clock after `vcc_gt_on` is seen high while charging, both startup currents are 0 and stay 0 until the block charges again.
- R4: `run_en` rises only after at least DLY_TICKS ticks since the end of charging, with the line qualified and `vcc_gt_off` high, and no startup current is ever on while `run_en` is 1.
- R5: Line qualification needs `line_gt_start` high for QUAL_TICKS consecutive ticks; any low cycle restarts it, and the line is not judged while a startup current is on.
- R6: While running, `line_gt_stop` low for BLANK_TICKS ticks clears `run_en` (brownout); switching resumes after the line requalifies, with no second startup delay.
- R7: The blanking count holds while the line sits between the stop and start levels and is cleared whenever the line is qualified.
- R8: `vcc_gt_ovp` high for OVP_TICKS consecutive ticks sets `ovp_latched` and forces all three enables to 0; the latch holds while `vcc_gt_rst` is 1 and clears one clock after it is 0, with the block charging again.
- R9: `vcc_gt_off` low for UV_TICKS consecutive ticks outside charging returns the block to charging; `run_en` stays 1 until that timeout ends.
- R10: With `rst_n` low at a clock edge, the block is charging: low current enabled, high current, `run_en` and `ovp_latched` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| vcc_gt_inh | input | 1 | Supply above inhibit level |
| vcc_gt_off | input | 1 | Supply above off level |
| vcc_gt_on | input | 1 | Supply above on level |
| vcc_gt_ovp | input | 1 | Supply above overvoltage level |
| vcc_gt_rst | input | 1 | Supply above reset level |
| line_gt_start | input | 1 | Line above start level |
| line_gt_stop | input | 1 | Line above stop level |
| istart_lo_en | output | 1 | Low startup current enable |
| istart_hi_en | output | 1 | High startup current enable |
| run_en | output | 1 | Switching allowed |
| ovp_latched | output | 1 | Supply overvoltage fault latched |

## Verification
The inhibit flag is toggled while charging, which separates the two charge stages and the return to the low current. The line is driven through four patterns: a qualification pulse that is too short, a full qualification, a dip below the stop level that is too short and then a long one, and a dwell between the two levels. Together they tell a hold of the blanking count apart from a clear, and a short dip apart from a real brownout. The overvoltage flag is pulsed once below and once above its window, and the reset flag is released late. This shows that the latch needs a full window and that it leaves only on a rail collapse. An undervoltage dip shorter than the timeout is separated from a full timeout by watching `run_en` stay high through the dip.

// File: rtl/supply_start_sequencer.sv
module supply_start_sequencer #(
  parameter int unsigned DLY_TICKS   = 34000,
  parameter int unsigned QUAL_TICKS  = 10000,
  parameter int unsigned BLANK_TICKS = 50000,
  parameter int unsigned OVP_TICKS   = 63000,
  parameter int unsigned UV_TICKS    = 42000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic vcc_gt_inh,
  input  logic vcc_gt_off,
  input  logic vcc_gt_on,
  input  logic vcc_gt_ovp,
  input  logic vcc_gt_rst,
  input  logic line_gt_start,
  input  logic line_gt_stop,
  output logic istart_lo_en,
  output logic istart_hi_en,
  output logic run_en,
  output logic ovp_latched
);

  localparam int DW = $clog2(DLY_TICKS + 1);
  localparam int QW = $clog2(QUAL_TICKS + 1);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam int OW = $clog2(OVP_TICKS + 1);
  localparam int UW = $clog2(UV_TICKS + 1);
  localparam logic [DW-1:0] DLY_L   = DW'(DLY_TICKS);
  localparam logic [QW-1:0] QUAL_L  = QW'(QUAL_TICKS);
  localparam logic [BW-1:0] BLANK_L = BW'(BLANK_TICKS);
  localparam logic [OW-1:0] OVP_L   = OW'(OVP_TICKS);
  localparam logic [UW-1:0] UV_L    = UW'(UV_TICKS);

  typedef enum logic [1:0] {S_CHARGE, S_ASSESS, S_RUN, S_FAULT} st_t;

  st_t st, nxt;
  logic [DW-1:0] dly_cnt;
  logic [QW-1:0] qual_cnt;
  logic [BW-1:0] blank_cnt;
  logic [OW-1:0] ovp_cnt;
  logic [UW-1:0] uv_cnt;

  wire judging    = (st == S_ASSESS) || (st == S_RUN);
  wire dly_full   = dly_cnt == DLY_L;
  wire qual_full  = qual_cnt == QUAL_L;
  wire blank_full = blank_cnt == BLANK_L;
  wire ovp_full   = ovp_cnt == OVP_L;
  wire uv_full    = uv_cnt == UV_L;

  assign istart_lo_en = (st == S_CHARGE) && !vcc_gt_inh;
  assign istart_hi_en = (st == S_CHARGE) && vcc_gt_inh;
  assign run_en       = st == S_RUN;
  assign ovp_latched  = st == S_FAULT;

  always_ff @(posedge clk) begin
    if (!rst_n || !judging) dly_cnt <= '0;
    else if (tick && !dly_full) dly_cnt <= dly_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !judging || !line_gt_start) qual_cnt <= '0;
    else if (tick && !qual_full) qual_cnt <= qual_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !judging || qual_full) blank_cnt <= '0;
    else if (tick && !line_gt_stop && !blank_full) blank_cnt <= blank_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !judging || vcc_gt_off) uv_cnt <= '0;
    else if (tick && !uv_full) uv_cnt <= uv_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (st == S_FAULT) || !vcc_gt_ovp) ovp_cnt <= '0;
    else if (tick && !ovp_full) ovp_cnt <= ovp_cnt + 1'b1;
  end

  always_comb begin
    nxt = st;
    case (st)
      S_CHARGE: if (vcc_gt_on) nxt = S_ASSESS;
      S_ASSESS: begin
        if (uv_full) nxt = S_CHARGE;
        else if (dly_full && qual_full && vcc_gt_off) nxt = S_RUN;
      end
      S_RUN: begin
        if (uv_full) nxt = S_CHARGE;
        else if (blank_full) nxt = S_ASSESS;
      end
      default: if (!vcc_gt_rst) nxt = S_CHARGE;
    endcase
    if (st != S_FAULT && ovp_full) nxt = S_FAULT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_CHARGE;
    else st <= nxt;
  end

  p_one_current_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(istart_lo_en && istart_hi_en));
  p_on_stops_charge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (istart_lo_en || istart_hi_en) && vcc_gt_on && !ovp_full |=> !istart_lo_en && !istart_hi_en);
  p_run_no_current_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> !istart_lo_en && !istart_hi_en);
  p_run_needs_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(vcc_gt_off));
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_latched |-> !run_en && !istart_lo_en && !istart_hi_en);
  p_fault_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_latched && vcc_gt_rst |=> ovp_latched);
  p_fault_exits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_latched && !vcc_gt_rst |=> !ovp_latched);

endmodule

// File: tb/sim_supply_start_sequencer.sv
module sim_supply_start_sequencer;
  localparam int DLY = 8, QUAL = 5, BLANK = 6, OVP = 7, UV = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0;
  logic inh = 0, off = 0, on = 0, ovp = 0, vrst = 0, lstart = 0, lstop = 0;
  logic lo, hi, run, fault;

  supply_start_sequencer #(.DLY_TICKS(DLY), .QUAL_TICKS(QUAL), .BLANK_TICKS(BLANK),
    .OVP_TICKS(OVP), .UV_TICKS(UV)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vcc_gt_inh(inh), .vcc_gt_off(off),
    .vcc_gt_on(on), .vcc_gt_ovp(ovp), .vcc_gt_rst(vrst), .line_gt_start(lstart),
    .line_gt_stop(lstop), .istart_lo_en(lo), .istart_hi_en(hi), .run_en(run),
    .ovp_latched(fault));

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  // reference model: 0 charging, 1 judging the line, 2 running, 3 overvoltage fault
  int m_st = 0, m_dly = 0, m_qual = 0, m_blank = 0, m_ovp = 0, m_uv = 0;

  always @(posedge clk) begin
    int ns;
    bit judge;
    judge = (m_st == 1) || (m_st == 2);
    ns = m_st;
    if (!rst_n) ns = 0;
    else begin
      if (m_st == 0 && on) ns = 1;
      else if (m_st == 1 && m_uv == UV) ns = 0;
      else if (m_st == 1 && m_dly == DLY && m_qual == QUAL && off) ns = 2;
      else if (m_st == 2 && m_uv == UV) ns = 0;
      else if (m_st == 2 && m_blank == BLANK) ns = 1;
      else if (m_st == 3 && !vrst) ns = 0;
      if (m_st != 3 && m_ovp == OVP) ns = 3;
    end
    if (!rst_n || !judge) begin m_dly = 0; m_qual = 0; m_blank = 0; m_uv = 0; end
    else begin
      if (tick && m_dly < DLY) m_dly++;
      if (m_qual == QUAL) m_blank = 0;
      else if (tick && !lstop && m_blank < BLANK) m_blank++;
      if (!lstart) m_qual = 0; else if (tick && m_qual < QUAL) m_qual++;
      if (off) m_uv = 0; else if (tick && m_uv < UV) m_uv++;
    end
    if (!rst_n || m_st == 3 || !ovp) m_ovp = 0;
    else if (tick && m_ovp < OVP) m_ovp++;
    m_st = ns;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk("R1 low current", lo, (m_st == 0) && !inh);
      chk("R2 high current", hi, (m_st == 0) && inh);
      chk("R4 run enable", run, m_st == 2);
      chk("R8 fault latch", fault, m_st == 3);
    end
    if (cyc % 4 == 0) #1 tick = 1'b1; else #1 tick = 1'b0;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    waitc(3);
    chk("R10 reset low current", lo, 1'b1);
    chk("R10 reset no high current", hi, 1'b0);
    chk("R10 reset no run", run, 1'b0);
    chk("R10 reset no fault", fault, 1'b0);
    rst_n = 1; vrst = 1;
    waitc(2);
    chk("R1 below inhibit", lo, 1'b1);
    inh = 1; waitc(1);
    chk("R2 above inhibit", hi, 1'b1);
    inh = 0; waitc(1);
    chk("R2 back to low", lo, 1'b1);
    inh = 1; off = 1; on = 1; waitc(2);
    chk("R3 low off", lo, 1'b0);
    chk("R3 high off", hi, 1'b0);
    waitc(48);
    lstart = 1; lstop = 1; waitc(12);
    lstart = 0; waitc(2);
    chk("R5 short qualification", run, 1'b0);
    lstart = 1; waitc(30);
    chk("R4 running", run, 1'b1);
    lstart = 0; lstop = 0; waitc(12);
    lstop = 1; waitc(40);
    chk("R7 band holds run", run, 1'b1);
    lstop = 0; waitc(20);
    chk("R6 brownout", run, 1'b0);
    lstart = 1; lstop = 1; waitc(30);
    chk("R6 resumes", run, 1'b1);
    lstart = 0; lstop = 0; waitc(16);
    lstart = 1; lstop = 1; waitc(28);
    lstart = 0; lstop = 0; waitc(16);
    chk("R7 requalify clears blanking", run, 1'b1);
    lstart = 1; lstop = 1; waitc(28);
    off = 0; on = 0; waitc(20);
    chk("R9 run kept in timeout", run, 1'b1);
    waitc(24);
    chk("R9 timeout stops run", run, 1'b0);
    chk("R9 charging again", hi, 1'b1);
    off = 1; on = 1; waitc(60);
    chk("R4 restart", run, 1'b1);
    ovp = 1; waitc(16);
    ovp = 0; waitc(4);
    chk("R8 short ovp ignored", fault, 1'b0);
    ovp = 1; waitc(40);
    chk("R8 latched", fault, 1'b1);
    chk("R8 run off", run, 1'b0);
    ovp = 0; waitc(20);
    chk("R8 holds above reset", fault, 1'b1);
    vrst = 0; inh = 0; off = 0; on = 0; waitc(2);
    chk("R8 cleared", fault, 1'b0);
    chk("R8 charging low", lo, 1'b1);
    waitc(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule